// File: doc/BRIEF.md
# Programmable periodic interrupt generator

This block raises an interrupt request at a fixed, software-chosen rate. The rate is measured in cycles of the oscillator clock. It comes from two dividers in series. The first is a power-of-two prescaler whose length is chosen by a 3-bit exponent code. The second is a modulus counter that repeats the prescaler interval 1 to 16 times. The exponent code 0 switches the whole timer off, whatever the modulus is.

Software sets the rate with one 7-bit control write. Every write starts counting again from zero. At the end of each period the block sets a sticky flag, and software clears that flag by writing a 1 to it. The interrupt request output is the flag masked by a separate enable input. A typical use is a steady tick that tells a processor to move a multiplexed display on to its next digit, without the processor having to sit in a delay loop.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset the control field is 0 (timer off), the flag is 0 and the interrupt request is 0.
- R2: A write with `ctl_wr` high loads `ctl_wdata`. Bits [6:4] are the exponent code k and bits [3:0] are the modulus code m.
- R3: Exponent codes k = 1 to 7 select a base interval of 2^(BASE_EXP+k) clock cycles. With the default BASE_EXP = 9 this gives 2^10 to 2^16.
- R4: The modulus code m (0 to 15) multiplies the base interval by m+1. A period end therefore occurs every (m+1)·2^(BASE_EXP+k) cycles, and this repeats without end.
- R5: Exponent code 0 stops the timer for every modulus value, and no period end occurs.
- R6: A control write clears the prescaler and the modulus counter and cancels any period end in the same cycle. The flag then next sets exactly P clock edges after the write edge, where P is the newly programmed period.
- R7: The flag stays set until a cycle in which `flag_clr` is high. That clear takes effect at the following edge.
- R8: When a period end and `flag_clr` occur in the same cycle, the flag is set.
- R9: `irq` equals the flag ANDed with `irq_en`. The flag still sets while `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control value: exponent [6:4], modulus [3:0] |
| flag_clr | input | 1 | Write-one clear of the tick flag |
| irq_en | input | 1 | Interrupt enable |
| tick_flag | output | 1 | Sticky period-end flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BASE_EXP = 1, so the base intervals shrink to 4 through 256 cycles. At that size it can measure two successive periods for every exponent code with moduli 0, 1 and 15, including the longest setting of 16·256 cycles. The same reduced size also lets it line up a flag clear exactly with a period end, cut a period short by rewriting the control field partway through, and watch the off state over several hundred cycles for both extreme moduli.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  typedef struct packed {
    logic [2:0] expo;
    logic [3:0] modu;
  } ctl_t;

  localparam logic [2:0] EXPO_OFF = 3'd0;

  // Length of one full period in clock cycles (0 when off).
  function automatic int unsigned period_len(input int unsigned base_exp,
                                             input logic [2:0] expo,
                                             input logic [3:0] modu);
    int unsigned len;
    if (expo == EXPO_OFF) begin
      len = 0;
    end else begin
      len = (int'(modu) + 1) << (base_exp + int'(expo));
    end
    return len;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned BASE_EXP = 9,
  localparam int unsigned PW = BASE_EXP + 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] expo,
  output logic       pre_tc
);
  import tick_irq_pkg::*;

  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] last_val;
  logic          running;

  // Terminal count of the prescaler: 2^(BASE_EXP+expo) - 1.
  function automatic logic [PW-1:0] term_count(input logic [2:0] e);
    logic [PW:0] one_hot;
    one_hot = (PW+1)'(1) << (BASE_EXP + int'(e));
    return PW'(one_hot - (PW+1)'(1));
  endfunction

  assign running  = (expo != EXPO_OFF);
  assign last_val = term_count(expo);
  assign pre_tc   = running && !restart && (pre_cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (restart || !running || pre_tc) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + PW'(1);
    end
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> pre_cnt <= last_val); // R3
  AST_PRE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> pre_cnt == '0); // R5

endmodule

// File: rtl/tick_modulus.sv
module tick_modulus #(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pre_tc,
  input  logic [MW-1:0] modu,
  output logic          period_end
);

  logic [MW-1:0] rep_cnt;

  assign period_end = pre_tc && (rep_cnt == modu);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_cnt <= '0;
    end else if (restart || period_end) begin
      rep_cnt <= '0;
    end else if (pre_tc) begin
      rep_cnt <= rep_cnt + MW'(1);
    end
  end

  AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_cnt <= modu); // R4
  AST_MOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> rep_cnt == '0); // R6

endmodule

// File: rtl/tick_flag_ctl.sv
module tick_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  assign req = flag & en;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag)); // R7
  AST_REQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !req); // R9

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen #(
  parameter int unsigned BASE_EXP = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [6:0] ctl_wdata,
  input  logic       flag_clr,
  input  logic       irq_en,
  output logic       tick_flag,
  output logic       irq
);
  import tick_irq_pkg::*;

  localparam int unsigned PW = BASE_EXP + 7;
  localparam int unsigned SW = PW + 5;

  ctl_t ctl_q;
  logic pre_tc;
  logic period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_t'(ctl_wdata);
    end
  end

  tick_prescaler #(.BASE_EXP(BASE_EXP)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctl_wr),
    .expo    (ctl_q.expo),
    .pre_tc  (pre_tc)
  );

  tick_modulus #(.MW(4)) u_mod (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (ctl_wr),
    .pre_tc     (pre_tc),
    .modu       (ctl_q.modu),
    .period_end (period_end)
  );

  tick_flag_ctl u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (period_end),
    .clr   (flag_clr),
    .en    (irq_en),
    .flag  (tick_flag),
    .req   (irq)
  );

  // Cycle span since the last restart or period end, kept for the period check.
  logic [SW-1:0] span_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_cnt <= '0;
    end else if (ctl_wr || period_end) begin
      span_cnt <= '0;
    end else begin
      span_cnt <= span_cnt + SW'(1);
    end
  end

  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (32'(span_cnt) + 1 == period_len(BASE_EXP, ctl_q.expo, ctl_q.modu))); // R4
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.expo == EXPO_OFF) |-> !period_end); // R5
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !period_end); // R6

endmodule

// File: tb/tick_irq_gen_tb.sv
module tick_irq_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_BASE    = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       tick_flag;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_irq_gen #(.BASE_EXP(TB_BASE)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .tick_flag (tick_flag),
    .irq       (irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(input int k, input int m);
    int base = 1;
    for (int i = 0; i < TB_BASE + k; i++) base = base * 2;
    return base * (m + 1);
  endfunction

  // Write control and clear the flag at the same edge; leaves us after that edge.
  task automatic program_ctl(input int k, input int m);
    @(negedge clk);
    ctl_wdata = 7'((k << 4) | m);
    ctl_wr    = 1'b1;
    flag_clr  = 1'b1;
    @(negedge clk);
    ctl_wr    = 1'b0;
    flag_clr  = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "flag after reset", int'(tick_flag), 0);
    check("R1", "irq after reset", int'(irq), 0);
    repeat (2000) @(posedge clk);
    #1;
    check("R1", "no tick while off after reset", int'(tick_flag), 0);
  endtask

  // R2 R3 R4 R6: measure two periods after a write
  task automatic t_period(input int k, input int m);
    int p = exp_period(k, m);
    int cnt = 0;
    int first = -1;
    int second = -1;
    program_ctl(k, m);
    while (cnt < 2 * p + 4) begin
      @(posedge clk); #1; cnt++;
      if (cnt == first + 1 && first > 0) flag_clr = 1'b0;
      if (tick_flag && first < 0) begin
        first = cnt;
        flag_clr = 1'b1;
      end else if (tick_flag && first > 0 && cnt > first + 1 && second < 0) begin
        second = cnt;
      end
    end
    flag_clr = 1'b0;
    check("R6", $sformatf("first period k=%0d m=%0d", k, m), first, p);
    check("R4", $sformatf("second period k=%0d m=%0d", k, m), second - first, p);
  endtask

  task automatic t_off(input int m);
    int seen = 0;
    program_ctl(0, m);
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      if (tick_flag) seen++;
    end
    check("R5", $sformatf("ticks with exponent 0, m=%0d", m), seen, 0);
  endtask

  task automatic t_restart;
    int cnt = 0;
    int p = exp_period(3, 1);
    program_ctl(3, 1);
    repeat (p - 5) @(posedge clk);
    program_ctl(3, 1);
    while (!tick_flag && cnt < 4 * p) begin
      @(posedge clk); #1; cnt++;
    end
    check("R6", "period after rewrite mid-count", cnt, p);
  endtask

  task automatic t_sticky;
    int p = exp_period(1, 0);
    program_ctl(1, 0);
    repeat (3 * p + 1) @(posedge clk);
    #1;
    check("R7", "flag held without clear", int'(tick_flag), 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R7", "flag after clear", int'(tick_flag), 0);
  endtask

  task automatic t_set_wins;
    int cnt = 0;
    program_ctl(1, 0);
    while (cnt < 7) begin @(posedge clk); #1; cnt++; end
    check("R7", "flag set at first period", int'(tick_flag), 1);
    flag_clr = 1'b1;
    @(posedge clk); #1; cnt++;
    check("R8", "set and clear together", int'(tick_flag), 1);
    @(posedge clk); #1; cnt++;
    flag_clr = 1'b0;
    check("R7", "clear one cycle later", int'(tick_flag), 0);
  endtask

  task automatic t_irq_gate;
    int p = exp_period(1, 1);
    irq_en = 1'b0;
    program_ctl(1, 1);
    repeat (p) @(posedge clk);
    #1;
    check("R9", "flag sets while disabled", int'(tick_flag), 1);
    check("R9", "irq masked", int'(irq), 0);
    irq_en = 1'b1; #1;
    check("R9", "irq follows enable", int'(irq), 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R9", "irq drops with flag", int'(irq), 0);
    irq_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_reset();
    for (int k = 1; k <= 7; k++) begin
      t_period(k, 0);
      t_period(k, 1);
      t_period(k, 15);
    end
    t_off(0);
    t_off(15);
    t_restart();
    t_sticky();
    t_set_wins();
    t_irq_gate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule